// File: doc/BRIEF.md
# Reset and Bus-Mode Strap Sequencer

This block sits on the host side of a serial peripheral. It takes the peripheral out of reset and, in the same step, picks the serial bus mode that the peripheral will use. The peripheral reads two strap pins at the rising edge of its active-low reset input. When a start request arrives with a mode code, the block latches the mode and the strap drive enables. It then drives the strap values, pulls the device reset low and keeps the serial clock and data lines at levels that cannot be mistaken for bus activity. After the required low time it releases reset, keeps the straps steady for a short hold and hands the pins back to the bus master, with a one-cycle done pulse.

All timing comes from a clock-frequency parameter, and every duration is rounded up to whole cycles. The reset low time is the longer of the minimum reset width and the 300 ns line guard. The minimum reset width is short (30 ns) when both strap pins are actively driven. It is long (100 µs) when either pin is left floating, because the device's weak internal pulls need that time to settle a floating pin.

Top module: `strap_reset_seq`

## Requirements
- R1: After reset: dev_rst_n_o=1, busy_o=0, done_o=0, err_o=0, bus_own_o=0, strap_oe_o=00, strap_o=00, scl_o=0, sda_o=0.
- R2: A start_i sampled high in idle with mode_i 0 (2-wire), 1 (3-wire) or 2 (SPI) makes busy_o and bus_own_o high from the next cycle. In that cycle strap_oe_o equals the latched strap_drv_en_i, and strap_o carries the mode's strap value (bit 0 = first strap pin): 2-wire 00, 3-wire 10, SPI 01.
- R3: With strap_drv_en_i=11 at start, dev_rst_n_o is low for max(ceil(30 ns), ceil(300 ns)) + 1 cycles (39 at 125 MHz).
- R4: With either strap_drv_en_i bit low at start, dev_rst_n_o is low for max(ceil(100 µs), ceil(300 ns)) + 1 cycles (12501 at 125 MHz).
- R5: strap_o and strap_oe_o stay constant from the first owned cycle until bus_own_o falls. This covers the reset rising edge and ceil(30 ns) + 1 cycles after it (5 at 125 MHz).
- R6: In 2-wire mode, scl_o=1 and sda_o=1 in every cycle in which bus_own_o=1. So no start condition occurs, and the clock is high at the reset release and at the hand-over.
- R7: In 3-wire and SPI modes, scl_o=0 and sda_o=0 in every cycle in which bus_own_o=1. So no rising clock edge occurs before the reset release.
- R8: The cycle after the last owned cycle has done_o=1, busy_o=1, bus_own_o=0, strap_oe_o=00 and dev_rst_n_o=1. In the cycle after that, busy_o=0.
- R9: A start_i sampled in idle with mode_i=3 gives err_o=1 for exactly the next cycle. busy_o stays 0 and dev_rst_n_o stays 1.
- R10: While busy_o=1, start_i, mode_i and strap_drv_en_i have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, sampled in idle |
| mode_i | input | 2 | Bus mode code: 0 2-wire, 1 3-wire, 2 SPI, 3 invalid |
| strap_drv_en_i | input | 2 | Per-pin strap drive enable (bit 0 first pin) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse on an invalid mode request |
| dev_rst_n_o | output | 1 | Active-low reset to the peripheral |
| bus_own_o | output | 1 | Serial lines and straps owned by this block |
| scl_o | output | 1 | Serial clock level while owned |
| sda_o | output | 1 | Serial data level while owned |
| strap_o | output | 2 | Strap pin values |
| strap_oe_o | output | 2 | Strap pin output enables |

## Verification
A bad internal state shows up at the ports within one cycle. A wrong phase length moves the rising edge of dev_rst_n_o, or the fall of bus_own_o, away from the cycle the bench model predicts. A bad latch of mode or drive enables changes strap_o, strap_oe_o or the serial line levels in the very first owned cycle. A bad timer choice between the short and long widths moves the reset release by thousands of cycles, and a low-time counter catches this at the release edge.

// File: rtl/strap_seq_pkg.sv
// Package: shared types and the time-to-cycle conversion for the strap
// sequencer. Assumes durations in nanoseconds and a clock in hertz.
package strap_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ASSERT_RST,
        S_GUARD,
        S_RELEASE,
        S_HOLD,
        S_DONE
    } seq_state_t;

    // Rounds ns * hz / 1e9 up; never returns fewer than one cycle.
    function automatic int unsigned ns_to_cycles(input longint unsigned ns,
                                                 input longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        return (c == 0) ? 32'd1 : 32'(c);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/strap_seq_timer.sv
// Module: loadable down-counter used to time each phase of the sequence.
// Assumes a load value of N-1 for an N-cycle phase; expired_o is high when
// the count has reached zero, and the counter then rests there.
module strap_seq_timer #(
    parameter int unsigned CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count down toward zero, or take a new phase length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);

    // R3 R4: without a load the count only ever steps down by one
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/strap_seq_mode_dec.sv
// Module: decodes the 2-bit bus mode code into a valid flag, the strap
// pattern for that mode and a 2-wire flag. Purely combinational.
module strap_seq_mode_dec #(
    parameter logic [1:0] STRAP_2W  = 2'b00,
    parameter logic [1:0] STRAP_3W  = 2'b10,
    parameter logic [1:0] STRAP_SPI = 2'b01
) (
    input  logic [1:0] mode_i,
    output logic       valid_o,
    output logic [1:0] straps_o,
    output logic       two_wire_o
);
    // Table lookup of the strap pattern per mode code.
    always_comb begin
        valid_o    = 1'b1;
        two_wire_o = 1'b0;
        straps_o   = 2'b00;
        unique case (mode_i)
            2'd0: begin straps_o = STRAP_2W; two_wire_o = 1'b1; end
            2'd1: straps_o = STRAP_3W;
            2'd2: straps_o = STRAP_SPI;
            default: valid_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/strap_reset_seq.sv
// Module: top of the reset and bus-mode strap sequencer. On an accepted
// start it drives straps, holds the peripheral in reset for the longer of
// the reset width and the line guard, releases reset, holds the straps,
// then hands the lines back. Assumes start_i is synchronous to clk.
module strap_reset_seq
    import strap_seq_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 125_000_000,
    parameter int unsigned     RST_LONG_NS  = 100_000,
    parameter int unsigned     RST_SHORT_NS = 30,
    parameter int unsigned     GUARD_NS     = 300,
    parameter int unsigned     HOLD_NS      = 30,
    parameter logic [1:0]      STRAP_2W     = 2'b00,
    parameter logic [1:0]      STRAP_3W     = 2'b10,
    parameter logic [1:0]      STRAP_SPI    = 2'b01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [1:0] mode_i,
    input  logic [1:0] strap_drv_en_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       dev_rst_n_o,
    output logic       bus_own_o,
    output logic       scl_o,
    output logic       sda_o,
    output logic [1:0] strap_o,
    output logic [1:0] strap_oe_o
);
    localparam int unsigned LONG_CYC  = ns_to_cycles(RST_LONG_NS, CLK_HZ);
    localparam int unsigned SHORT_CYC = ns_to_cycles(RST_SHORT_NS, CLK_HZ);
    localparam int unsigned GUARD_CYC = ns_to_cycles(GUARD_NS, CLK_HZ);
    localparam int unsigned HOLD_CYC  = ns_to_cycles(HOLD_NS, CLK_HZ);
    localparam int unsigned PRE_LONG  = max_u(LONG_CYC, GUARD_CYC);
    localparam int unsigned PRE_SHORT = max_u(SHORT_CYC, GUARD_CYC);
    localparam int unsigned MAX_LOAD  = max_u(PRE_LONG, max_u(GUARD_CYC, HOLD_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_LOAD + 1);

    seq_state_t       state_q, state_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;
    logic             mode_ok, mode_2w;
    logic [1:0]       mode_straps;
    logic [1:0]       straps_q, oe_q;
    logic             two_wire_q, long_q, err_q;
    logic             accept, pick_long;

    strap_seq_mode_dec #(
        .STRAP_2W (STRAP_2W),
        .STRAP_3W (STRAP_3W),
        .STRAP_SPI(STRAP_SPI)
    ) u_dec (
        .mode_i    (mode_i),
        .valid_o   (mode_ok),
        .straps_o  (mode_straps),
        .two_wire_o(mode_2w)
    );

    strap_seq_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (ld),
        .load_val_i(ld_val),
        .expired_o (expired)
    );

    assign accept    = (state_q == S_IDLE) && start_i && mode_ok;
    assign pick_long = ~&strap_drv_en_i;

    // Next phase and the timer load that starts it.
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        ld_val  = '0;
        unique case (state_q)
            S_IDLE: if (accept) begin
                state_d = S_ASSERT_RST;
                ld      = 1'b1;
                ld_val  = pick_long ? CNT_W'(PRE_LONG - GUARD_CYC)
                                    : CNT_W'(PRE_SHORT - GUARD_CYC);
            end
            S_ASSERT_RST: if (expired) begin
                state_d = S_GUARD;
                ld      = 1'b1;
                ld_val  = CNT_W'(GUARD_CYC - 1);
            end
            S_GUARD: if (expired) state_d = S_RELEASE;
            S_RELEASE: begin
                state_d = S_HOLD;
                ld      = 1'b1;
                ld_val  = CNT_W'(HOLD_CYC - 1);
            end
            S_HOLD: if (expired) state_d = S_DONE;
            default: state_d = S_IDLE;
        endcase
    end

    // Phase register, configuration latch and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            straps_q   <= 2'b00;
            oe_q       <= 2'b00;
            two_wire_q <= 1'b0;
            long_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= (state_q == S_IDLE) && start_i && !mode_ok;
            if (accept) begin
                straps_q   <= mode_straps;
                oe_q       <= strap_drv_en_i;
                two_wire_q <= mode_2w;
                long_q     <= pick_long;
            end
        end
    end

    // Output decode from the current phase.
    always_comb begin
        bus_own_o   = (state_q == S_ASSERT_RST) || (state_q == S_GUARD) ||
                      (state_q == S_RELEASE)    || (state_q == S_HOLD);
        dev_rst_n_o = !((state_q == S_ASSERT_RST) || (state_q == S_GUARD));
        busy_o      = (state_q != S_IDLE);
        done_o      = (state_q == S_DONE);
        err_o       = err_q;
        strap_o     = bus_own_o ? straps_q : 2'b00;
        strap_oe_o  = bus_own_o ? oe_q : 2'b00;
        scl_o       = bus_own_o && two_wire_q;
        sda_o       = bus_own_o && two_wire_q;
    end

    // Low-time counter for the reset width check.
    logic [CNT_W:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || dev_rst_n_o)
            low_cnt <= '0;
        else
            low_cnt <= low_cnt + 1'b1;
    end

    // R3 R4
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n_o) |->
            (low_cnt >= (long_q ? (CNT_W+1)'(PRE_LONG) : (CNT_W+1)'(PRE_SHORT))));

    // R5
    strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RELEASE || state_q == S_HOLD) |->
            ($stable(strap_o) && $stable(strap_oe_o)));

    // R6
    two_wire_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own_o && two_wire_q) |-> (scl_o && sda_o));

    // R7
    no_clk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_own_o && !two_wire_q) |-> !$rose(scl_o));

    // R8
    done_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (busy_o && !bus_own_o && dev_rst_n_o) ##1 !busy_o);

    // R9
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && !mode_ok) |=> (err_o && !busy_o && dev_rst_n_o));

endmodule

// File: tb/tb_strap_reset_seq.sv
module tb_strap_reset_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] en = 2'b11;
    logic busy, done, err, drst_n, own, scl, sda;
    logic [1:0] strap, strap_oe;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    strap_reset_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
        .strap_drv_en_i(en), .busy_o(busy), .done_o(done), .err_o(err),
        .dev_rst_n_o(drst_n), .bus_own_o(own), .scl_o(scl), .sda_o(sda),
        .strap_o(strap), .strap_oe_o(strap_oe)
    );

    // Durations at 8 ns per cycle, rounded up.
    function automatic int cyc_of(input int ns);
        return (ns + 7) / 8;
    endfunction
    localparam int HOLD_C = (30 + 7) / 8;

    function automatic int low_len(input logic [1:0] e);
        int w, g;
        w = (e == 2'b11) ? cyc_of(30) : cyc_of(100_000);
        g = cyc_of(300);
        return ((w > g) ? w : g) + 1;
    endfunction

    function automatic logic [1:0] strap_of(input logic [1:0] m);
        return (m == 2'd0) ? 2'b00 : (m == 2'd1) ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Reference model: elapsed cycles since an accepted start.
    bit         m_act = 0;
    int         m_n = 0;
    bit         m_err = 0;
    logic [1:0] m_mode = 0, m_en = 0;
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_act = 0; m_n = 0; m_err = 0;
        end else begin
            m_err = 0;
            if (m_act) begin
                m_n++;
                if (m_n == low_len(m_en) + 3 + HOLD_C) m_act = 0;
            end else if (start) begin
                if (mode == 2'd3) m_err = 1;
                else begin m_act = 1; m_n = 1; m_mode = mode; m_en = en; end
            end
        end
    end

    // Compare every output against the model away from the active edge.
    int low_run = 0;
    always @(negedge clk) begin
        if (cmp_on) begin
            int  L;
            bit  e_own, e_low;
            L     = low_len(m_en);
            e_own = m_act && (m_n <= L + 1 + HOLD_C);
            e_low = m_act && (m_n <= L);
            check(busy == m_act, "R8 busy", busy, m_act);
            check(done == (m_act && m_n == L + 2 + HOLD_C), "R8 done", done,
                  m_act && m_n == L + 2 + HOLD_C);
            check(own == e_own, "R2 bus_own", own, e_own);
            check(drst_n == !e_low, (m_en == 2'b11) ? "R3 dev_rst_n" : "R4 dev_rst_n",
                  drst_n, !e_low);
            check(strap_oe == (e_own ? m_en : 2'b00), "R5 strap_oe", strap_oe,
                  e_own ? m_en : 2'b00);
            check(strap == (e_own ? strap_of(m_mode) : 2'b00), "R5 strap", strap,
                  e_own ? strap_of(m_mode) : 2'b00);
            check({scl, sda} == ((e_own && m_mode == 0) ? 2'b11 : 2'b00),
                  (m_mode == 0) ? "R6 scl/sda" : "R7 scl/sda", {scl, sda},
                  (e_own && m_mode == 0) ? 3 : 0);
            check(err == m_err, "R9 err", err, m_err);
            // Measured reset low length at each release.
            if (!drst_n) low_run++;
            else begin
                if (low_run != 0)
                    check(low_run == L, (m_en == 2'b11) ? "R3 low width" : "R4 low width",
                          low_run, L);
                low_run = 0;
            end
        end
    end

    task automatic go(input logic [1:0] m, input logic [1:0] e);
        @(negedge clk);
        start = 1'b1; mode = m; en = e;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (150_000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({busy, done, err, own, scl, sda} == 6'b0, "R1 flags", {busy, done, err, own, scl, sda}, 0);
        check(drst_n == 1'b1 && strap_oe == 2'b00 && strap == 2'b00, "R1 pins",
              {drst_n, strap_oe, strap}, 16);
        cmp_on = 1;

        go(2'd0, 2'b11); wait_idle();          // R3 R6: 2-wire, driven straps
        // R10: requests and input changes during a 3-wire run
        go(2'd1, 2'b11);
        repeat (5) @(negedge clk);
        start = 1'b1; mode = 2'd2; en = 2'b00;
        repeat (10) @(negedge clk);
        start = 1'b0; mode = 2'd3;
        check(busy == 1'b1 && strap == 2'b10 && strap_oe == 2'b11, "R10 latched",
              {busy, strap, strap_oe}, 5'b11011);
        wait_idle();
        go(2'd2, 2'b01); wait_idle();          // R4 R7: SPI, one pin floating
        go(2'd3, 2'b11); repeat (3) @(negedge clk); // R9
        check(busy == 1'b0 && drst_n == 1'b1, "R9 no start", {busy, drst_n}, 1);
        go(2'd0, 2'b00); wait_idle();          // R4 R6: 2-wire, both floating
        go(2'd2, 2'b11); wait_idle();          // R3 R7: SPI, driven
        // Back-to-back request directly after completion.
        go(2'd1, 2'b10);
        @(negedge clk);
        while (!done) @(negedge clk);
        start = 1'b1; mode = 2'd0; en = 2'b11;
        @(negedge clk);
        start = 1'b0;
        wait_idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule